// File: doc/BRIEF.md
# Stretching CPU Clock Prescaler

This block makes the clock for a CPU core out of the system clock. A 3-bit divide code selects the ratio. With code zero the CPU clock is the system clock itself, with the same period and phase. With a nonzero code N the block lets through only one system clock cycle in every N+1. In the cycles it leaves out, the CPU clock stays high. The result is a clock that is high for most of each period and low for one short phase, not a 50% duty square wave. The system clock itself is not touched, so peripherals keep running at full rate.

The same high-level stretch serves three control inputs. An external-memory wait and a bus request hold the CPU clock high for as long as they are asserted. A stop input, used during wait-for-interrupt, stops the CPU clock completely and freezes the divide counter. Alongside the gated clock the block gives a one-cycle enable, `cpu_clk_en`. It is high in exactly the system clock cycle whose low phase reaches the CPU clock, so logic that runs on the system clock can follow the CPU's pace.

All control inputs are plain level pins and have no handshake. They are sampled within the cycle in which they are presented and must be stable before the falling edge of the system clock.

Top module: `cpuclk_stretch_top`

## Requirements
- R1: While `rst` is high, `cpu_clk` is high and `cpu_clk_en` is low. After `rst` falls, the first enable cycle is cycle index `div_code` (counting from 0 at the first cycle out of reset), provided no hold is applied.
- R2: With `div_code` = 0 and no hold, `cpu_clk_en` is high in every cycle and `cpu_clk` is low in every low phase of `sys_clk`.
- R3: With a nonzero `div_code` N and no hold, `cpu_clk_en` is high exactly once every N+1 cycles, in the last cycle of each period, so the ratio runs from 2 (code 1) to 8 (code 7).
- R4: `cpu_clk` is high during every high phase of `sys_clk`. It is low during a low phase only when `cpu_clk_en` is high in that cycle.
- R5: While `mem_wait` or `bus_req` is high, `cpu_clk_en` is low and `cpu_clk` stays high. The period counter keeps advancing up to the last cycle of the period and waits there. The enable cycle comes in the first cycle in which both inputs are low.
- R6: While `wfi_stop` is high, `cpu_clk_en` is low, `cpu_clk` stays high and the period counter does not advance.
- R7: `div_code` is sampled only in the first cycle of each period. A change made later takes effect at the next period boundary, so no shortened period is produced.
- R8: A hold input applied in a cycle suppresses that same cycle's low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; also the undivided peripheral timebase |
| rst | input | 1 | Synchronous reset, active high |
| div_code | input | 3 | Divide code: 0 = pass-through, N = divide by N+1 |
| mem_wait | input | 1 | External memory wait; stretches `cpu_clk` high |
| bus_req | input | 1 | Bus request; stretches `cpu_clk` high |
| wfi_stop | input | 1 | Wait-for-interrupt stop; freezes the CPU clock and the counter |
| cpu_clk | output | 1 | Gated, high-stretched CPU clock |
| cpu_clk_en | output | 1 | High in the cycle whose low phase appears on `cpu_clk` |

## Verification
A wrong period count or a wrong latched code shows up in the first period where it matters. The enable comes one or more cycles early or late, and the CPU clock's low phase moves with it, so the bench checks every cycle of each vector against a position computed from the code. A counter that advances during stop, or that fails to wait at the last cycle during a memory wait, moves the next enable by the length of the hold. A code taken up in mid-period shortens the period in progress. The directed tests change the code, hold the clock and release it at chosen cycles so that each of these faults shows within a few cycles.

// File: rtl/cpuclk_stretch_pkg.sv
package cpuclk_stretch_pkg;
  localparam int unsigned CODE_W = 3;
  typedef logic [CODE_W-1:0] div_code_t;

  typedef struct packed {
    logic hold;  // memory wait or bus request
    logic stop;  // wait-for-interrupt stop
  } hold_req_t;
endpackage

// File: rtl/cpuclk_period_ctr.sv
module cpuclk_period_ctr
  import cpuclk_stretch_pkg::*;
#(
  parameter int unsigned CW = CODE_W
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [CW-1:0] code_i,
  input  logic          stop_i,
  input  logic          release_i,
  output logic          term_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] code_o
);
  localparam logic [CW-1:0] ZERO = '0;

  logic [CW-1:0] cnt_q, code_q, eff_code;
  logic          at_start;

  assign at_start = (cnt_q == ZERO);
  // the code is read live only in the first cycle of a period
  assign eff_code = at_start ? code_i : code_q;
  assign term_o   = (cnt_q == eff_code);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= ZERO;
      code_q <= ZERO;
    end else begin
      if (at_start) code_q <= eff_code;
      if (!stop_i) begin
        if (term_o) begin
          if (release_i) cnt_q <= ZERO;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign code_o = eff_code;
endmodule

// File: rtl/cpuclk_hold_qual.sv
module cpuclk_hold_qual
  import cpuclk_stretch_pkg::*;
(
  input  logic      rst_i,
  input  logic      mem_wait_i,
  input  logic      bus_req_i,
  input  logic      wfi_stop_i,
  input  logic      term_i,
  output hold_req_t req_o,
  output logic      release_o,
  output logic      qual_o
);
  always_comb begin
    req_o.hold = mem_wait_i | bus_req_i;
    req_o.stop = wfi_stop_i;
    release_o  = ~(req_o.hold | req_o.stop);
    qual_o     = term_i & release_o & ~rst_i;
  end
endmodule

// File: rtl/cpuclk_gate_cell.sv
module cpuclk_gate_cell (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);
  logic en_lat;

  // transparent during the high phase, closed through the low phase
  always_latch begin
    if (clk_i) en_lat = en_i;
  end

  // high-stretching gate: low phase passes only when enabled
  assign gclk_o = clk_i | ~en_lat;
endmodule

// File: rtl/cpuclk_stretch_top.sv
module cpuclk_stretch_top
  import cpuclk_stretch_pkg::*;
#(
  parameter int unsigned DIV_W = CODE_W
) (
  input  logic             sys_clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_code,
  input  logic             mem_wait,
  input  logic             bus_req,
  input  logic             wfi_stop,
  output logic             cpu_clk,
  output logic             cpu_clk_en
);
  logic             term;
  logic             release_ok;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] code_eff;
  hold_req_t        req;

  cpuclk_period_ctr #(.CW(DIV_W)) ctr_i (
    .clk_i    (sys_clk),
    .rst_i    (rst),
    .code_i   (div_code),
    .stop_i   (req.stop),
    .release_i(release_ok),
    .term_o   (term),
    .cnt_o    (cnt_q),
    .code_o   (code_eff)
  );

  cpuclk_hold_qual qual_i (
    .rst_i     (rst),
    .mem_wait_i(mem_wait),
    .bus_req_i (bus_req),
    .wfi_stop_i(wfi_stop),
    .term_i    (term),
    .req_o     (req),
    .release_o (release_ok),
    .qual_o    (cpu_clk_en)
  );

  cpuclk_gate_cell gate_i (
    .clk_i (sys_clk),
    .en_i  (cpu_clk_en),
    .gclk_o(cpu_clk)
  );
endmodule

// File: rtl/cpuclk_stretch_chk.sv
module cpuclk_stretch_chk #(
  parameter int unsigned DIV_W = 3
) (
  input logic             sys_clk,
  input logic             rst,
  input logic             mem_wait,
  input logic             bus_req,
  input logic             wfi_stop,
  input logic             cpu_clk_en,
  input logic [DIV_W-1:0] cnt_q,
  input logic [DIV_W-1:0] code_eff
);
  p_hold_blocks_r5: assert property (@(posedge sys_clk) disable iff (rst)
    (mem_wait || bus_req) |-> !cpu_clk_en);

  p_stop_blocks_r6: assert property (@(posedge sys_clk) disable iff (rst)
    wfi_stop |-> !cpu_clk_en);

  p_stop_freeze_r6: assert property (@(posedge sys_clk) disable iff (rst)
    wfi_stop |=> $stable(cnt_q));

  p_wrap_after_en_r3: assert property (@(posedge sys_clk) disable iff (rst)
    cpu_clk_en |=> (cnt_q == '0));

  p_code_held_r7: assert property (@(posedge sys_clk) disable iff (rst)
    (cnt_q != '0) |-> $stable(code_eff));
endmodule

bind cpuclk_stretch_top cpuclk_stretch_chk #(.DIV_W(DIV_W)) chk_i (
  .sys_clk   (sys_clk),
  .rst       (rst),
  .mem_wait  (mem_wait),
  .bus_req   (bus_req),
  .wfi_stop  (wfi_stop),
  .cpu_clk_en(cpu_clk_en),
  .cnt_q     (cnt_q),
  .code_eff  (code_eff)
);

// File: tb/cpuclk_stretch_top_tb_top.sv
`timescale 1ns/1ps
module cpuclk_stretch_top_tb_top;
  logic       sys_clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] div_code = '0;
  logic       mem_wait = 1'b0, bus_req = 1'b0, wfi_stop = 1'b0;
  logic       cpu_clk, cpu_clk_en;

  int n_chk = 0, n_bad = 0;

  always #4 sys_clk = ~sys_clk;  // 125 MHz

  cpuclk_stretch_top dut_i (
    .sys_clk(sys_clk), .rst(rst), .div_code(div_code),
    .mem_wait(mem_wait), .bus_req(bus_req), .wfi_stop(wfi_stop),
    .cpu_clk(cpu_clk), .cpu_clk_en(cpu_clk_en)
  );

  // vector: code, mem_wait, bus_req, stop, length in cycles
  typedef struct packed {
    logic [2:0] code;
    logic       mw, br, st;
    logic [4:0] len;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 1'b0, 1'b0, 5'd6},
    '{3'd1, 1'b0, 1'b0, 1'b0, 5'd8},
    '{3'd2, 1'b0, 1'b0, 1'b0, 5'd9},
    '{3'd3, 1'b0, 1'b0, 1'b0, 5'd12},
    '{3'd4, 1'b0, 1'b0, 1'b0, 5'd15},
    '{3'd5, 1'b0, 1'b0, 1'b0, 5'd18},
    '{3'd6, 1'b0, 1'b0, 1'b0, 5'd21},
    '{3'd7, 1'b0, 1'b0, 1'b0, 5'd24},
    '{3'd3, 1'b1, 1'b0, 1'b0, 5'd10},
    '{3'd0, 1'b0, 1'b1, 1'b0, 5'd6},
    '{3'd2, 1'b0, 1'b0, 1'b1, 5'd9}
  };

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // called at posedge+1; checks one cycle, returns at next posedge+1
  task automatic cycle(input logic exp_en, input string req);
    #1 check(cpu_clk, 1'b1, "R4 high phase");
    #4 check(cpu_clk_en, exp_en, req);
    check(cpu_clk, ~exp_en, "R4 low phase");
    @(posedge sys_clk); #1;
  endtask

  task automatic start(input logic [2:0] c);
    rst = 1'b1; div_code = c;
    mem_wait = 0; bus_req = 0; wfi_stop = 0;
    repeat (2) @(posedge sys_clk);
    #1 rst = 1'b0;
  endtask

  initial begin
    // R1: reset state
    rst = 1'b1;
    repeat (2) @(posedge sys_clk);
    #5;
    check(cpu_clk_en, 1'b0, "R1 reset enable");
    check(cpu_clk, 1'b1, "R1 reset clock high");

    // table walk: R1 R2 R3 R5 R6
    for (int v = 0; v < NV; v++) begin
      start(VECS[v].code);
      mem_wait = VECS[v].mw; bus_req = VECS[v].br; wfi_stop = VECS[v].st;
      for (int k = 0; k < int'(VECS[v].len); k++) begin
        logic e;
        e = !(VECS[v].mw || VECS[v].br || VECS[v].st) &&
            ((k % (int'(VECS[v].code) + 1)) == int'(VECS[v].code));
        cycle(e, VECS[v].code == 0 ? "R2 pass-through" : "R3 divide / R5 R6 hold");
      end
    end

    // R7: code change mid-period waits for boundary
    start(3'd3);
    cycle(0, "R7"); div_code = 3'd1;
    cycle(0, "R7"); cycle(0, "R7"); cycle(1, "R7 old period kept");
    cycle(0, "R7 new code"); cycle(1, "R7 new code");

    // R5: wait reaches terminal, pulse on release
    start(3'd2);
    mem_wait = 1;
    cycle(0, "R5"); cycle(0, "R5"); cycle(0, "R5"); cycle(0, "R5");
    mem_wait = 0;
    cycle(1, "R5 release pulse");
    cycle(0, "R5"); cycle(0, "R5"); cycle(1, "R5 next period");

    // R6: stop freezes counter
    start(3'd2);
    cycle(0, "R6");
    wfi_stop = 1;
    cycle(0, "R6"); cycle(0, "R6"); cycle(0, "R6");
    wfi_stop = 0;
    cycle(0, "R6 frozen count"); cycle(1, "R6 resumed pulse");

    // R8: hold in terminal cycle suppresses that cycle only
    start(3'd0);
    cycle(1, "R8");
    bus_req = 1; cycle(0, "R8 same-cycle suppress");
    bus_req = 0; cycle(1, "R8");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule